// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five localities owns a security module's register window. Each locality reaches the block through its own 4 KB page of the register space. An access register sits at offset zero of that page and is one byte wide. A host asks for the device by setting the request bit in its locality's access register. The owning locality gives the device up by writing the active bit. The block keeps one pending-request flag per locality, grants ownership when the window is free, and passes ownership on when the owner releases. Every change of owner produces a one-cycle locality-change pulse, which interrupt logic elsewhere turns into status bit 2.

The slave side is a single-cycle register bus. Read data is combinational from the address while a read strobe is high. A write takes effect at the clock edge on which it is strobed. The current owner is also available on dedicated outputs, so that neighbouring blocks can route their per-locality pages.

Top module: `locality_arbiter`

## Requirements
- R1: After reset no locality owns the device, `loc_chg_o` is low, and the access register of every locality reads 0x80.
- R2: Address bits [14:12] select the locality and bits [11:0] must be zero to reach its access register. Reads of any other offset, or of localities 5 to 7, return 0x00. Writes to those addresses change nothing.
- R3: An access register read returns the following bits. Bit 7 is always 1. Bit 5 is 1 when this locality owns the device. Bit 2 is 1 when any other locality has a request pending. Bit 1 is 1 when this locality has its own request pending. All other bits are 0.
- R4: A write with bit 1 set from a locality that does not own the device sets that locality's pending request. The same write from the owner has no effect.
- R5: When no locality owns the device and requests are pending, the highest-numbered pending locality is granted at the next clock edge and its pending flag is cleared.
- R6: A write with bit 5 set from the owner releases ownership at that edge. If other requests are pending, the highest-numbered one is granted at the same edge and is visible in the next cycle. Otherwise the device becomes unowned.
- R7: A write with bit 5 set from a locality that is not the owner, including a write while the device is unowned, changes neither the owner nor any pending flag.
- R8: `loc_chg_o` is high for exactly one cycle after each edge at which the owner changes, including a change to unowned. At all other times it is low.
- R9: `owner_vld_o` and `owner_o` always show the current owner. `owner_o` is meaningful only while `owner_vld_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 15 | Byte address: locality in [14:12], page offset in [11:0] |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational while a read is strobed |
| owner_vld_o | output | 1 | A locality owns the device |
| owner_o | output | 3 | Number of the owning locality |
| loc_chg_o | output | 1 | One-cycle pulse after each owner change |

## Verification
Requests are exercised in three situations. A request to an unowned device shows the one-cycle gap between the pending flag and the grant. Requests queued behind an owner show the pending bits as seen from the owner and from the waiters. Release chains show handover to the highest pending locality, then to the only remaining one, then to unowned. Writes that must be ignored are checked by reading the access registers and the owner outputs afterwards. These writes are an owner re-request, a release from a non-owner, a release while idle, writes to a wrong offset, and writes to a nonexistent locality. Together they tell a stray state change apart from correct filtering.

// File: rtl/locality_pkg.sv
package locality_pkg;
  localparam int unsigned ACC_VALID_BIT  = 7;
  localparam int unsigned ACC_ACTIVE_BIT = 5;
  localparam int unsigned ACC_OTHER_BIT  = 2;
  localparam int unsigned ACC_REQ_BIT    = 1;

  typedef struct packed {
    logic hit;
    logic wr_req;
    logic wr_rel;
    logic rd;
  } acc_cmd_t;
endpackage

// File: rtl/loc_decode.sv
module loc_decode
  import locality_pkg::*;
#(
  parameter int unsigned N_LOC     = 5,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned LOC_W    = $clog2(N_LOC),
  localparam int unsigned ADDR_W   = PAGE_BITS + LOC_W
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [LOC_W-1:0]  loc_o,
  output acc_cmd_t          cmd_o
);
  logic hit;
  assign loc_o = addr_i[PAGE_BITS +: LOC_W];
  assign hit   = (32'(loc_o) < N_LOC) && (addr_i[PAGE_BITS-1:0] == '0);

  always_comb begin
    cmd_o.hit    = hit;
    cmd_o.rd     = req_i && !we_i && hit;
    cmd_o.wr_req = req_i && we_i && hit && wdata_i[ACC_REQ_BIT];
    cmd_o.wr_rel = req_i && we_i && hit && wdata_i[ACC_ACTIVE_BIT];
  end
endmodule

// File: rtl/loc_prio.sv
module loc_prio #(
  parameter int unsigned N_LOC = 5,
  localparam int unsigned LOC_W = $clog2(N_LOC)
) (
  input  logic [N_LOC-1:0] pend_i,
  output logic             any_o,
  output logic [LOC_W-1:0] idx_o,
  output logic [N_LOC-1:0] oh_o
);
  // highest index wins: later iterations override earlier ones
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_LOC; i++) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = LOC_W'(i);
      end
    end
    oh_o = any_o ? (N_LOC'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/loc_rdmux.sv
module loc_rdmux
  import locality_pkg::*;
#(
  parameter int unsigned N_LOC = 5,
  localparam int unsigned LOC_W = $clog2(N_LOC)
) (
  input  logic             rd_i,
  input  logic [LOC_W-1:0] loc_i,
  input  logic             owner_vld_i,
  input  logic [LOC_W-1:0] owner_i,
  input  logic [N_LOC-1:0] pend_i,
  output logic [7:0]       rdata_o
);
  logic [N_LOC-1:0] self_oh;
  assign self_oh = N_LOC'(1) << loc_i;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      rdata_o[ACC_VALID_BIT]  = 1'b1;
      rdata_o[ACC_ACTIVE_BIT] = owner_vld_i && (owner_i == loc_i);
      rdata_o[ACC_OTHER_BIT]  = |(pend_i & ~self_oh);
      rdata_o[ACC_REQ_BIT]    = |(pend_i & self_oh);
    end
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import locality_pkg::*;
#(
  parameter int unsigned N_LOC     = 5,
  parameter int unsigned PAGE_BITS = 12,
  localparam int unsigned LOC_W    = $clog2(N_LOC),
  localparam int unsigned ADDR_W   = PAGE_BITS + LOC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              owner_vld_o,
  output logic [LOC_W-1:0]  owner_o,
  output logic              loc_chg_o
);
  logic [LOC_W-1:0] dec_loc;
  acc_cmd_t         cmd;
  logic [N_LOC-1:0] pend_q, pend_d, set_oh;
  logic             owner_vld_q, owner_vld_d;
  logic [LOC_W-1:0] owner_q, owner_d;
  logic             chg_q, chg_d;
  logic             pr_any;
  logic [LOC_W-1:0] pr_idx;
  logic [N_LOC-1:0] pr_oh;
  logic             own_wr, do_rel, do_gnt;

  loc_decode #(.N_LOC(N_LOC), .PAGE_BITS(PAGE_BITS)) u_dec (
    .req_i(bus_req_i), .we_i(bus_we_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .loc_o(dec_loc), .cmd_o(cmd)
  );

  // owner's own flag is never set, so the pick always excludes it
  loc_prio #(.N_LOC(N_LOC)) u_prio (
    .pend_i(pend_q), .any_o(pr_any), .idx_o(pr_idx), .oh_o(pr_oh)
  );

  loc_rdmux #(.N_LOC(N_LOC)) u_rd (
    .rd_i(cmd.rd), .loc_i(dec_loc), .owner_vld_i(owner_vld_q),
    .owner_i(owner_q), .pend_i(pend_q), .rdata_o(bus_rdata_o)
  );

  always_comb begin
    own_wr      = owner_vld_q && (dec_loc == owner_q);
    set_oh      = (cmd.wr_req && !own_wr) ? (N_LOC'(1) << dec_loc) : '0;
    do_rel      = cmd.wr_rel && own_wr;
    do_gnt      = pr_any && (do_rel || !owner_vld_q);
    owner_vld_d = owner_vld_q;
    owner_d     = owner_q;
    if (do_gnt) begin
      owner_vld_d = 1'b1;
      owner_d     = pr_idx;
    end else if (do_rel) begin
      owner_vld_d = 1'b0;
    end
    pend_d = (pend_q | set_oh) & ~(do_gnt ? pr_oh : '0);
    chg_d  = do_gnt || do_rel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= '0;
      owner_vld_q <= 1'b0;
      owner_q     <= '0;
      chg_q       <= 1'b0;
    end else begin
      pend_q      <= pend_d;
      owner_vld_q <= owner_vld_d;
      owner_q     <= owner_d;
      chg_q       <= chg_d;
    end
  end

  assign owner_vld_o = owner_vld_q;
  assign owner_o     = owner_q;
  assign loc_chg_o   = chg_q;

  // R4
  owner_not_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_vld_q |-> !pend_q[owner_q]);

  // R5
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_vld_q && pend_q != '0) |=> owner_vld_q);

  // R6
  handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.wr_rel && owner_vld_q && dec_loc == owner_q && pend_q != '0)
      |=> owner_vld_q && owner_q != $past(owner_q));

  // R7
  foreign_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd.wr_rel && !cmd.wr_req && owner_vld_q && dec_loc != owner_q)
      |=> owner_vld_q && $stable(owner_q) && $stable(pend_q));

  // R8
  chg_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_vld_q != $past(owner_vld_q)) |-> loc_chg_o);
endmodule

// File: tb/sim_locality_arbiter.sv
module sim_locality_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ovld, chg;
  logic [2:0]  own;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  locality_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .owner_vld_o(ovld), .owner_o(own), .loc_chg_o(chg)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // strobe one write across a rising edge; returns at the following negedge
  task automatic wr(int loc, logic [7:0] d, logic [11:0] off = '0);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {3'(loc), off}; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int loc, output logic [7:0] d, input logic [11:0] off = '0);
    req = 1'b1; we = 1'b0; addr = {3'(loc), off};
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic expect_acc(string tag, int loc, int exp);
    logic [7:0] d;
    rd(loc, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset();
    for (int l = 0; l < 5; l++) expect_acc("R1 reset access", l, 8'h80);
    check("R1 reset owner_vld", ovld, 0);
    check("R1 reset loc_chg", chg, 0);
  endtask

  task automatic t_idle_grant();
    wr(2, 8'h02);
    expect_acc("R3 own request before grant", 2, 8'h82);
    check("R5 no grant yet", ovld, 0);
    @(negedge clk);
    check("R5 granted", ovld, 1);
    check("R9 owner", own, 2);
    check("R8 pulse on grant", chg, 1);
    expect_acc("R3 owner reads active", 2, 8'hA0);
    @(negedge clk);
    check("R8 pulse one cycle", chg, 0);
  endtask

  task automatic t_queue();
    wr(0, 8'h02);
    wr(3, 8'h02);
    check("R4 owner kept", own, 2);
    expect_acc("R3 owner sees others", 2, 8'hA4);
    expect_acc("R3 waiter 3", 3, 8'h86);
    expect_acc("R3 waiter 0", 0, 8'h86);
    wr(2, 8'h02);
    expect_acc("R4 owner re-request no-op", 2, 8'hA4);
    check("R8 no pulse on no-op", chg, 0);
    wr(3, 8'h20);
    check("R7 foreign release owner", own, 2);
    check("R7 foreign release vld", ovld, 1);
    expect_acc("R7 foreign release pending kept", 3, 8'h86);
  endtask

  task automatic t_handover();
    wr(2, 8'h20);
    check("R6 handover to highest", own, 3);
    check("R6 still owned", ovld, 1);
    check("R8 pulse on handover", chg, 1);
    expect_acc("R6 new owner", 3, 8'hA4);
    expect_acc("R6 old owner", 2, 8'h84);
    wr(3, 8'h20);
    check("R6 handover to last", own, 0);
    expect_acc("R6 last owner", 0, 8'hA0);
    wr(0, 8'h20);
    check("R6 release to idle", ovld, 0);
    check("R8 pulse on idle", chg, 1);
    expect_acc("R6 idle access", 0, 8'h80);
    wr(1, 8'h20);
    check("R7 idle release vld", ovld, 0);
    check("R7 idle release no pulse", chg, 0);
  endtask

  task automatic t_addr_map();
    logic [7:0] d;
    wr(1, 8'h02, 12'h004);
    expect_acc("R2 wrong offset write ignored", 1, 8'h80);
    @(negedge clk);
    check("R2 wrong offset no grant", ovld, 0);
    wr(5, 8'h02);
    @(negedge clk);
    check("R2 locality 5 no grant", ovld, 0);
    rd(5, d);
    check("R2 locality 5 reads zero", d, 0);
    rd(0, d, 12'h018);
    check("R2 other offset reads zero", d, 0);
    wr(4, 8'h02);
    @(negedge clk);
    check("R5 grant locality 4", own, 4);
    check("R9 vld", ovld, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_grant();
    t_queue();
    t_handover();
    t_addr_map();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule